// File: doc/BRIEF.md
# Audio Silence Detector with Mute and Amplifier Power-Down

The block watches a stream of signed 16-bit audio samples and decides whether the input has gone quiet. Each sample comes with a valid strobe. The block takes the absolute value of the sample and compares it with two thresholds. The low threshold is used to decide when to enter silence. The high threshold, set one step louder, is used to decide when to leave it. Time is measured in observation windows. A window counts pulses of a 1 ms tick input, and a long-window mode stretches it to tens of seconds.

A state machine has three states:

- **ST_OFF**: detection is disabled.
- **ST_LISTEN**: detection is on and the input is treated as audible.
- **ST_QUIET**: silence has been declared.

It moves between them on four transitions:

- **ARM** (ST_OFF to ST_LISTEN): the disable input is low.
- **ENTER** (ST_LISTEN to ST_QUIET): a window closes with too few samples above the low threshold.
- **LEAVE** (ST_QUIET to ST_LISTEN): too many samples above the high threshold have been seen inside the current window.
- **DISARM** (any state to ST_OFF): the disable input is high.

In ST_QUIET the block raises a mute request and a status flag. If auto power-down is enabled, it also requests that the power amplifier be switched off. The configuration fields come straight from a register bank that is not part of this block; the disable field is expected to reset to 1.

Top module: `hush_detect`

## Requirements
- R1: While `det_off` is 1, the machine is in ST_OFF and `mute_req`, `quiet_flag` and `pa_down_req` are all 0, starting from the clock after it is sampled. Reset also leaves the machine in ST_OFF with all outputs 0.
- R2: A sample is counted only when `smp_vld` is 1. Its magnitude is the absolute value of `smp_data` read as two's complement, so -32768 has magnitude 32768 and -5 has magnitude 5.
- R3: A sample counts as a low event when its magnitude is strictly greater than 2^(k+1), where k is `lo_thr_sel`. This is 0.25·2^k units at 8 magnitude codes per unit, so code 0 gives 2 and code 7 gives 256.
- R4: A sample counts as a high event when its magnitude is strictly greater than 2^(k+2), where k is `hi_thr_sel`. Code 0 gives 4 and code 7 gives 512.
- R5: With `win_long` set to 0, `win_sel` codes 0 to 7 select windows of 50, 100, 200, 400, 1000, 2000, 4000 and 8000 ticks.
- R6: With `win_long` set to 1, `win_sel` codes 0 to 7 select windows of 16000, 24000, 32000, 40000, 48000, 56000, 60000 and 64000 ticks.
- R7: ENTER fires at the clock edge that closes a window in ST_LISTEN if the low-event count for that window, including a sample taken on that edge, is below 2^`enter_sel`. On ENTER, `mute_req` and `quiet_flag` become 1. After an arm, the first window closes on edge len+1.
- R8: LEAVE fires in ST_QUIET on the first edge at which the high-event count in the current window exceeds 16·2^`leave_sel` − 1 (15 up to 2047). It does not wait for the window to end. On LEAVE, `mute_req` and `quiet_flag` return to 0.
- R9: `pa_down_req` is 1 exactly when the machine is in ST_QUIET and `auto_pd_en` is 1.
- R10: Both event counters restart at every window boundary and on LEAVE. A change to any configuration field other than `det_off` restarts the window and both counters without changing the state.
- R11: The window advances only on clocks where `tick_ms` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed audio sample |
| tick_ms | input | 1 | One-clock pulse every millisecond |
| det_off | input | 1 | 1 disables detection |
| lo_thr_sel | input | 3 | Entry (low) threshold code |
| hi_thr_sel | input | 3 | Exit (high) threshold code |
| win_sel | input | 3 | Window length code |
| win_long | input | 1 | Selects the long window table |
| enter_sel | input | 3 | Entry count limit code |
| leave_sel | input | 3 | Exit count limit code |
| auto_pd_en | input | 1 | Enables the amplifier power-down request |
| mute_req | output | 1 | Mute request |
| quiet_flag | output | 1 | Silence status flag |
| pa_down_req | output | 1 | Amplifier power-down request |

## Verification
The bench targets the off-by-one edges of every comparison, each swept across all codes:

- **Thresholds.** A sample exactly at a threshold is fed, then one just above it. A design using greater-or-equal would enter silence too rarely or leave it too early.
- **Count limits.** Exactly the limit, and one more than the limit, is fed for both the entry and the exit count. A design with swapped or shifted limits would change state one sample early or late.
- **Window lengths.** Every window length is timed to the exact closing edge. A window counter that wraps one tick off would be caught there.
- **Counter restarts.** Samples are split across two windows, and a configuration field is changed mid-window. A design that lets counts accumulate, or keeps the window running after a configuration change, would enter silence at the wrong time.
- **Input gating.** The tick is held low, large samples are fed with the strobe low, and -32768 is used as a sample value. This exposes a timer that runs on the clock, a design that counts invalid samples, and a magnitude computation that overflows.

// File: rtl/hush_pkg.sv
package hush_pkg;

    localparam int SEL_W = 3;
    localparam int WIN_W = 16;
    localparam int ENT_W = (1 << SEL_W);
    localparam int EXT_W = (1 << SEL_W) + 4;
    localparam int CFG_W = 5 * SEL_W + 2;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_LISTEN = 2'd1,
        ST_QUIET  = 2'd2
    } hush_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] lo_sel;
        logic [SEL_W-1:0] hi_sel;
        logic [SEL_W-1:0] win_sel;
        logic             win_long;
        logic [SEL_W-1:0] ent_sel;
        logic [SEL_W-1:0] ext_sel;
        logic             apd;
    } hush_cfg_t;

    // Window length in ms ticks for a code and table choice.
    function automatic logic [WIN_W-1:0] win_ticks(input logic [SEL_W-1:0] sel,
                                                   input logic lng);
        int t;
        if (lng) begin
            if (sel == SEL_W'(7))      t = 64000;
            else if (sel == SEL_W'(6)) t = 60000;
            else                       t = 16000 + 8000 * int'(sel);
        end else if (sel[2]) begin
            t = 1000 << sel[1:0];
        end else begin
            t = 50 << sel[1:0];
        end
        return WIN_W'(t);
    endfunction

    // Number of low events below which a window counts as silent.
    function automatic logic [ENT_W-1:0] enter_limit(input logic [SEL_W-1:0] sel);
        return ENT_W'(1) << sel;
    endfunction

    // Number of high events that must be exceeded to leave silence.
    function automatic logic [EXT_W-1:0] leave_limit(input logic [SEL_W-1:0] sel);
        return (EXT_W'(16) << sel) - EXT_W'(1);
    endfunction

endpackage

// File: rtl/hush_mag.sv
module hush_mag #(
    parameter int SAMPLE_W   = 16,
    parameter int UNIT_SHIFT = 3
) (
    input  logic [SAMPLE_W-1:0]       data,
    input  logic                      vld,
    input  logic [hush_pkg::SEL_W-1:0] lo_sel,
    input  logic [hush_pkg::SEL_W-1:0] hi_sel,
    output logic                      lo_hit,
    output logic                      hi_hit
);
    localparam int MAG_W = SAMPLE_W + 1;
    localparam int LO_BASE = UNIT_SHIFT - 2;
    localparam int HI_BASE = UNIT_SHIFT - 1;

    logic signed [MAG_W-1:0] ext;
    logic [MAG_W-1:0]        mag;
    logic [MAG_W-1:0]        thr [2];
    logic [1:0]              hit;

    always_comb begin
        ext = {data[SAMPLE_W-1], data};
        mag = data[SAMPLE_W-1] ? MAG_W'(-ext) : MAG_W'(ext);
    end

    // One comparator per ladder; the high ladder sits one doubling above.
    for (genvar g = 0; g < 2; g++) begin : g_ladder
        localparam int BASE = (g == 0) ? LO_BASE : HI_BASE;
        always_comb begin
            thr[g] = MAG_W'(1) << (BASE + int'((g == 0) ? lo_sel : hi_sel));
            hit[g] = vld && (mag > thr[g]);
        end
    end

    assign lo_hit = hit[0];
    assign hi_hit = hit[1];

endmodule

// File: rtl/hush_win_timer.sv
module hush_win_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] len,
    output logic [W-1:0] cnt,
    output logic         win_end
);
    assign win_end = tick && !restart && (cnt >= len - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (restart)   cnt <= '0;
        else if (win_end)   cnt <= '0;
        else if (tick)      cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/hush_evt_cnt.sv
module hush_evt_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic [W-1:0] nxt
);
    // Saturating: the limit compared against always stays below all-ones.
    assign nxt = (&cnt) ? cnt : cnt + W'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else             cnt <= nxt;
    end

endmodule

// File: rtl/hush_detect.sv
module hush_detect
    import hush_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int UNIT_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                tick_ms,
    input  logic                det_off,
    input  logic [2:0]          lo_thr_sel,
    input  logic [2:0]          hi_thr_sel,
    input  logic [2:0]          win_sel,
    input  logic                win_long,
    input  logic [2:0]          enter_sel,
    input  logic [2:0]          leave_sel,
    input  logic                auto_pd_en,
    output logic                mute_req,
    output logic                quiet_flag,
    output logic                pa_down_req
);
    hush_state_e state_q, state_d;
    hush_cfg_t   cfg, cfg_q;
    logic        cfg_chg;

    logic             lo_hit, hi_hit;
    logic             restart, win_end, cnt_clr;
    logic [WIN_W-1:0] win_len, win_cnt;
    logic [ENT_W-1:0] lo_cnt, lo_nxt, ent_lim;
    logic [EXT_W-1:0] hi_cnt, hi_nxt, ext_lim;
    logic             enter_ev, leave_ev;

    // Configuration snapshot: any change restarts the window.
    always_comb begin
        cfg.lo_sel   = lo_thr_sel;
        cfg.hi_sel   = hi_thr_sel;
        cfg.win_sel  = win_sel;
        cfg.win_long = win_long;
        cfg.ent_sel  = enter_sel;
        cfg.ext_sel  = leave_sel;
        cfg.apd      = auto_pd_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg;
    end

    assign cfg_chg = (cfg != cfg_q);
    assign win_len = win_ticks(win_sel, win_long);
    assign ent_lim = enter_limit(enter_sel);
    assign ext_lim = leave_limit(leave_sel);

    hush_mag #(
        .SAMPLE_W  (SAMPLE_W),
        .UNIT_SHIFT(UNIT_SHIFT)
    ) u_mag (
        .data  (smp_data),
        .vld   (smp_vld),
        .lo_sel(lo_thr_sel),
        .hi_sel(hi_thr_sel),
        .lo_hit(lo_hit),
        .hi_hit(hi_hit)
    );

    assign restart = (state_q == ST_OFF) || cfg_chg || leave_ev;
    assign cnt_clr = restart || win_end;

    hush_win_timer #(.W(WIN_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .tick   (tick_ms),
        .len    (win_len),
        .cnt    (win_cnt),
        .win_end(win_end)
    );

    hush_evt_cnt #(.W(ENT_W)) u_lo_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clr),
        .inc  (lo_hit),
        .cnt  (lo_cnt),
        .nxt  (lo_nxt)
    );

    hush_evt_cnt #(.W(EXT_W)) u_hi_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clr),
        .inc  (hi_hit),
        .cnt  (hi_cnt),
        .nxt  (hi_nxt)
    );

    // Transition conditions
    assign enter_ev = (state_q == ST_LISTEN) && !det_off && win_end && (lo_nxt < ent_lim);
    assign leave_ev = (state_q == ST_QUIET) && !det_off && !cfg_chg && (hi_nxt > ext_lim);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!det_off) state_d = ST_LISTEN;          // ARM
            end
            ST_LISTEN: begin
                if (det_off)       state_d = ST_OFF;        // DISARM
                else if (enter_ev) state_d = ST_QUIET;      // ENTER
            end
            ST_QUIET: begin
                if (det_off)       state_d = ST_OFF;        // DISARM
                else if (leave_ev) state_d = ST_LISTEN;     // LEAVE
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        mute_req    = 1'b0;
        quiet_flag  = 1'b0;
        pa_down_req = 1'b0;
        unique case (state_q)
            ST_OFF, ST_LISTEN: ;
            ST_QUIET: begin
                mute_req    = 1'b1;
                quiet_flag  = 1'b1;
                pa_down_req = auto_pd_en;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hush_detect_chk.sv
module hush_detect_chk
    import hush_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             det_off,
    input logic             auto_pd_en,
    input logic             mute_req,
    input logic             pa_down_req,
    input logic             win_end,
    input logic             cfg_chg,
    input logic [WIN_W-1:0] win_cnt,
    input logic [WIN_W-1:0] win_len,
    input logic [ENT_W-1:0] lo_cnt,
    input logic [EXT_W-1:0] hi_cnt,
    input logic [EXT_W-1:0] hi_nxt,
    input logic [EXT_W-1:0] ext_lim
);
    a_r1_off_silences: assert property (@(posedge clk) disable iff (!rst_n)
        det_off |=> (!mute_req && !pa_down_req));

    a_r7_enter_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_req) |-> $past(win_end));

    a_r8_leave_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute_req) |-> ($past(det_off) || $past(hi_nxt > ext_lim)));

    a_r9_pd_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pa_down_req |-> (mute_req && auto_pd_en));

    a_r10_counts_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(win_end) |-> (lo_cnt == '0 && hi_cnt == '0));

    a_r5_timer_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> (win_cnt < win_len));

endmodule

bind hush_detect hush_detect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_off    (det_off),
    .auto_pd_en (auto_pd_en),
    .mute_req   (mute_req),
    .pa_down_req(pa_down_req),
    .win_end    (win_end),
    .cfg_chg    (cfg_chg),
    .win_cnt    (win_cnt),
    .win_len    (win_len),
    .lo_cnt     (lo_cnt),
    .hi_cnt     (hi_cnt),
    .hi_nxt     (hi_nxt),
    .ext_lim    (ext_lim)
);

// File: tb/hush_detect_tb_top.sv
module hush_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_data = '0;
    logic        tick_ms = 1'b1;
    logic        det_off = 1'b1;
    logic [2:0]  lo_thr_sel = '0, hi_thr_sel = '0, win_sel = '0;
    logic        win_long = 1'b0;
    logic [2:0]  enter_sel = '0, leave_sel = '0;
    logic        auto_pd_en = 1'b0;
    logic        mute_req, quiet_flag, pa_down_req;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hush_detect dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .tick_ms(tick_ms), .det_off(det_off), .lo_thr_sel(lo_thr_sel),
        .hi_thr_sel(hi_thr_sel), .win_sel(win_sel), .win_long(win_long),
        .enter_sel(enter_sel), .leave_sel(leave_sel), .auto_pd_en(auto_pd_en),
        .mute_req(mute_req), .quiet_flag(quiet_flag), .pa_down_req(pa_down_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic feed(input int n, input logic [15:0] v);
        for (int i = 0; i < n; i++) begin
            smp_vld = 1'b1;
            smp_data = v;
            @(negedge clk);
        end
        smp_vld = 1'b0;
        smp_data = '0;
    endtask

    task automatic rearm();
        det_off = 1'b1;
        step(2);
        det_off = 1'b0;
    endtask

    function automatic int short_len(input int c);
        return (c < 4) ? (50 << c) : (1000 << (c - 4));
    endfunction

    task automatic get_quiet();
        lo_thr_sel = 0; enter_sel = 0; win_sel = 0; win_long = 0;
        rearm();
        step(51);
        check("R7 quiet reached", int'(mute_req), 1);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(3);
        check("R1 reset mute", int'(mute_req), 0);
        check("R1 reset flag", int'(quiet_flag), 0);
        check("R1 reset pd", int'(pa_down_req), 0);
        rst_n = 1'b1;

        // R1: disabled, silent input, nothing happens
        step(300);
        check("R1 off stays audible", int'(mute_req), 0);

        // R5: every short window, exact closing edge
        for (int c = 0; c < 8; c++) begin
            win_sel = 3'(c); win_long = 0; enter_sel = 0;
            rearm();
            step(short_len(c));
            check($sformatf("R5 code %0d before", c), int'(mute_req), 0);
            step(1);
            check($sformatf("R5 code %0d close", c), int'(quiet_flag), 1);
        end

        // R6: long windows, codes 0 and 7
        for (int k = 0; k < 2; k++) begin
            automatic int c = (k == 0) ? 0 : 7;
            automatic int len = (c == 0) ? 16000 : 64000;
            win_sel = 3'(c); win_long = 1;
            rearm();
            step(len);
            check($sformatf("R6 code %0d before", c), int'(mute_req), 0);
            step(1);
            check($sformatf("R6 code %0d close", c), int'(mute_req), 1);
        end
        win_long = 0;

        // R3: low threshold ladder, sample at and just above the threshold
        for (int k = 0; k < 8; k++) begin
            automatic int thr = 2 << k;
            for (int above = 0; above < 2; above++) begin
                automatic int m = thr + above;
                lo_thr_sel = 3'(k); win_sel = 0; enter_sel = 0;
                rearm();
                step(3);
                feed(1, (above != 0) ? 16'(-m) : 16'(m));
                step(47);
                check($sformatf("R3 code %0d mag %0d", k, m), int'(mute_req), (above != 0) ? 0 : 1);
            end
        end
        lo_thr_sel = 0;

        // R7: entry limit ladder, limit-1 events enters, limit events does not
        for (int c = 0; c < 8; c++) begin
            for (int extra = 0; extra < 2; extra++) begin
                automatic int m = (1 << c) - 1 + extra;
                win_sel = 2; enter_sel = 3'(c);
                rearm();
                step(3);
                feed(m, 16'd3);
                step(201 - 3 - m);
                check($sformatf("R7 limit code %0d events %0d", c, m), int'(mute_req), (extra != 0) ? 0 : 1);
            end
        end
        enter_sel = 0;

        // R8 + R2: exit limit ladder, mid-window leave
        for (int c = 0; c < 8; c++) begin
            automatic int lim = (16 << c) - 1;
            leave_sel = 3'(c); hi_thr_sel = 0;
            get_quiet();
            win_sel = 7;
            step(2);
            if (c == 0) begin
                smp_vld = 1'b0; smp_data = 16'h7fff;
                step(40);
                check("R2 invalid samples ignored", int'(mute_req), 1);
            end
            feed(lim, (c == 0) ? 16'h8000 : 16'd5000);
            check($sformatf("R8 code %0d at limit", c), int'(mute_req), 1);
            feed(1, 16'd5000);
            check($sformatf("R8 code %0d over limit", c), int'(mute_req), 0);
            check($sformatf("R8 code %0d flag", c), int'(quiet_flag), 0);
        end
        leave_sel = 0;

        // R4: high threshold ladder
        for (int k = 0; k < 8; k++) begin
            automatic int thr = 4 << k;
            hi_thr_sel = 3'(k);
            get_quiet();
            win_sel = 7;
            step(2);
            feed(16, 16'(-thr));
            check($sformatf("R4 code %0d at thr", k), int'(mute_req), 1);
            feed(16, 16'(thr + 1));
            check($sformatf("R4 code %0d above thr", k), int'(mute_req), 0);
        end
        hi_thr_sel = 0;

        // R10: counters restart at window boundary
        win_sel = 0; enter_sel = 1;
        rearm();
        step(3);
        feed(2, 16'd100);
        step(46);
        check("R10 first window busy", int'(mute_req), 0);
        step(5);
        feed(1, 16'd100);
        step(44);
        check("R10 second window fresh count", int'(mute_req), 1);
        enter_sel = 0;

        // R10: configuration change restarts the window
        win_sel = 0; lo_thr_sel = 0;
        rearm();
        step(30);
        lo_thr_sel = 1;
        step(30);
        check("R10 cfg restart not yet", int'(mute_req), 0);
        step(20);
        check("R10 cfg restart edge-1", int'(mute_req), 0);
        step(1);
        check("R10 cfg restart close", int'(mute_req), 1);
        lo_thr_sel = 0;

        // R11: no tick, no window
        tick_ms = 0;
        rearm();
        step(200);
        check("R11 frozen without tick", int'(mute_req), 0);
        tick_ms = 1;
        step(60);
        check("R11 resumes with tick", int'(mute_req), 1);

        // R9: power-down request
        auto_pd_en = 0;
        get_quiet();
        check("R9 pd off when disabled", int'(pa_down_req), 0);
        auto_pd_en = 1;
        #1;
        check("R9 pd on in quiet", int'(pa_down_req), 1);
        step(2);
        check("R9 quiet kept on cfg change", int'(mute_req), 1);
        win_sel = 7;
        step(2);
        feed(16, 16'd1000);
        check("R9 pd released on leave", int'(pa_down_req), 0);

        // R1: disabling while quiet clears everything
        get_quiet();
        det_off = 1;
        step(1);
        check("R1 disarm mute", int'(mute_req), 0);
        check("R1 disarm pd", int'(pa_down_req), 0);
        check("R1 disarm flag", int'(quiet_flag), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule